// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that fronts a byte-wide storage array held in registers. It runs on the system clock. The bus lines are brought in through two-flop synchronizers, and bus edges are found on the synchronized copies. The slave pulls the data line low through an output enable and never drives it high. A host addresses the block with a device byte whose upper nibble is a fixed code. The page-select bits of that byte carry the word-address bits that do not fit in the second byte.

Writes go into a page-sized staging buffer that has one valid flag per byte. A stop moves only the staged bytes into the array. It then starts a self-timed write cycle, and during that cycle the slave ignores the bus, so a host polls for completion by repeating the device byte. Reads come from an internal address counter that persists between transactions. This gives current-address, random (dummy write and then repeated start) and sequential reads. The array size must be a power of two of at least 256 bytes and at most 2048 bytes. The page size is a power of two.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Only a start (data falling while clock is high) opens a transaction, and a stop (data rising while clock is high) closes it. A device byte clocked in without a preceding start is not acknowledged.
- R2: The device byte is sent MSB first. Bits [7:4] must equal 1010 and bit 0 selects read (1) or write (0). On a match the slave pulls data low during the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next start.
- R3: With the default 512-byte array, device-byte bit 1 is word-address bit 8. A device byte with bit 3 or bit 2 set is not acknowledged.
- R4: In a write, the byte after the device byte is the low 8 bits of the word address, and every following byte is data. The slave acknowledges each byte with 0.
- R5: During a write only the low 4 address bits advance, and they wrap inside the 16-byte page. A 17th or later byte overwrites an earlier byte of the same page, and neighbouring pages are unchanged.
- R6: Only the data bytes that were received are stored. The other bytes of the page keep their old values.
- R7: A stop after at least one data byte starts a write cycle that lasts WR_CYCLES system clocks. During the cycle no device byte is acknowledged, and the slave acknowledges again once the cycle ends.
- R8: A stop that follows the word address with no data bytes starts no write cycle, and the next device byte is acknowledged at once.
- R9: The address counter holds the last address accessed plus one. A current-address read returns the byte at the counter.
- R10: A random read (device byte with write, word address, repeated start, device byte with read) returns the byte at the loaded address.
- R11: In a sequential read each host acknowledge (0) yields the next byte. The address wraps from the last array byte to byte 0.
- R12: A host no-acknowledge (1) after a read byte ends the read. The slave drives nothing more until the next start.
- R13: The slave changes its data drive only while the clock line is low. It drives nothing while idle or during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
The bench pushes page writes past the 16-byte boundary, starting near the end of a page. A design that carried into the upper address bits would corrupt the next page instead of overwriting the start of the same one. It reads sequentially across the array end, where a design that wrapped inside a page on reads would return the wrong bytes. It also reads a page after a three-byte write, where a design that committed a whole page would zero the untouched bytes. It polls right after a stop and checks that the first poll goes unanswered and a later one is answered. The same polling check, run after a stop with no data, shows whether a spurious write cycle starts. Finally it clocks extra bits after a host no-acknowledge, and a slave that kept reading would pull the line low there.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HB = (AW > 8) ? AW - 8 : 0;
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] HMASK = 3'((1 << HB) - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_READ} st_t;

  st_t state;
  logic [2:0] scl_p, sda_p;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [AW-1:0] ptr;
  logic [2:0] hi;
  logic [7:0] shreg, txsh;
  logic [3:0] bitcnt;
  logic ack_slot, rw, mack, busy;
  logic [CW-1:0] bcnt;

  wire scl_s     = scl_p[1];
  wire scl_rise  = scl_s & ~scl_p[2];
  wire scl_fall  = ~scl_s & scl_p[2];
  wire scl_hi    = scl_s & scl_p[2];
  wire start_det = scl_hi & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_hi & ~sda_p[2] & sda_p[1];
  wire pend      = |pvalid;
  wire in_idle   = (state == S_IDLE);
  wire dev_ok    = (shreg[7:4] == 4'b1010) && ((shreg[3:1] & ~HMASK) == 3'b000);
  wire [10:0] full_adr = {hi & HMASK, shreg};
  wire [AW-1:0] wr_next = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};

  assign sda_oe = ack_slot ? (state != S_READ) : ((state == S_READ) & ~txsh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      scl_p <= 3'b111;
      sda_p <= 3'b111;
      pvalid <= '0;
      ptr <= '0;
      hi <= '0;
      shreg <= '0;
      txsh <= 8'hFF;
      bitcnt <= '0;
      ack_slot <= 1'b0;
      rw <= 1'b0;
      mack <= 1'b0;
      busy <= 1'b0;
      bcnt <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
      if (busy) begin
        if (bcnt == '0) busy <= 1'b0;
        else bcnt <= bcnt - 1'b1;
        state <= S_IDLE;
        ack_slot <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE;
        ack_slot <= 1'b0;
        if (pend) begin
          busy <= 1'b1;
          bcnt <= CW'(WR_CYCLES - 1);
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pvalid[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
          pvalid <= '0;
        end
      end else if (start_det) begin
        state <= S_DEV;
        bitcnt <= '0;
        ack_slot <= 1'b0;
        pvalid <= '0;
      end else if (!in_idle) begin
        if (state == S_READ) begin
          if (!ack_slot) begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) ack_slot <= 1'b1;
              else txsh <= {txsh[6:0], 1'b1};
            end
          end else begin
            if (scl_rise) mack <= ~sda_p[1];
            if (scl_fall) begin
              ack_slot <= 1'b0;
              bitcnt <= '0;
              if (mack) begin
                txsh <= mem[ptr];
                ptr <= ptr + 1'b1;
              end else begin
                state <= S_IDLE;
                txsh <= 8'hFF;
              end
            end
          end
        end else if (!ack_slot) begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_p[1]};
            bitcnt <= bitcnt + 1'b1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            case (state)
              S_DEV: begin
                if (dev_ok) begin
                  ack_slot <= 1'b1;
                  rw <= shreg[0];
                  hi <= shreg[3:1];
                end else state <= S_IDLE;
              end
              S_WADR: begin
                ptr <= full_adr[AW-1:0];
                ack_slot <= 1'b1;
              end
              S_WDAT: begin
                pbuf[ptr[PW-1:0]] <= shreg;
                pvalid[ptr[PW-1:0]] <= 1'b1;
                ptr <= wr_next;
                ack_slot <= 1'b1;
              end
              default: ;
            endcase
          end
        end else if (scl_fall) begin
          ack_slot <= 1'b0;
          bitcnt <= '0;
          case (state)
            S_DEV: begin
              if (rw) begin
                state <= S_READ;
                txsh <= mem[ptr];
                ptr <= ptr + 1'b1;
              end else state <= S_WADR;
            end
            S_WADR: state <= S_WDAT;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
  parameter int WR_CYCLES = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic busy,
  input logic stop_det,
  input logic pend,
  input logic in_idle,
  input logic sda_oe
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else busy_len <= busy ? busy_len + 1 : 0;
  end

  assert_idle_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det && pend));

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == WR_CYCLES));

  assert_drive_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .busy(busy), .stop_det(stop_det),
  .pend(pend), .in_idle(in_idle), .sda_oe(sda_oe)
);

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;
  localparam int Q = 8;
  localparam int WRC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  wire sda_line = host_sda & ~sda_oe;

  always #4 clk = ~clk;

  twi_eeprom_slave #(.MEM_BYTES(512), .PAGE_BYTES(16), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  int total = 0;
  int fails = 0;
  logic [7:0] model [512];
  logic [8:0] mptr = '0;
  logic [7:0] wbuf [32];

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] wr_next(input logic [8:0] p);
    return {p[8:4], p[3:0] + 4'd1};
  endfunction

  function automatic logic [8:0] rd_next(input logic [8:0] p);
    return p + 9'd1;
  endfunction

  function automatic logic [7:0] dev_byte(input logic [8:0] a, input bit rd);
    return {4'b1010, 2'b00, a[8], rd};
  endfunction

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; hw();
    scl = 1'b1; hw();
    host_sda = 1'b0; hw();
    scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; hw();
    scl = 1'b1; hw();
    host_sda = 1'b1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; hw();
      scl = 1'b1; hw();
      scl = 1'b0; hw();
    end
    host_sda = 1'b1; hw();
    scl = 1'b1; hw();
    ack = ~sda_line;
    scl = 1'b0; hw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw();
      scl = 1'b1; hw();
      b[i] = sda_line;
      scl = 1'b0;
    end
    host_sda = ~give_ack; hw();
    scl = 1'b1; hw();
    scl = 1'b0; hw();
    host_sda = 1'b1;
  endtask

  task automatic rd_seq(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check(b == model[mptr], req, b, model[mptr]);
      mptr = rd_next(mptr);
    end
    bus_stop();
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    bit ack;
    logic [8:0] p;
    bus_start();
    send_byte(dev_byte(a, 1'b0), ack);
    check(ack, "R4 device ack", ack, 1);
    send_byte(a[7:0], ack);
    check(ack, "R4 word address ack", ack, 1);
    p = a;
    for (int j = 0; j < n; j++) begin
      send_byte(wbuf[j], ack);
      check(ack, "R4 data ack", ack, 1);
      model[p] = wbuf[j];
      p = wr_next(p);
    end
    bus_stop();
    mptr = p;
  endtask

  task automatic poll_once(output bit ack);
    bus_start();
    send_byte(dev_byte(9'd0, 1'b0), ack);
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    do begin
      poll_once(ack);
      polls++;
    end while (!ack && polls < 50);
    check(ack, "R7 ack returns after write cycle", ack, 1);
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(dev_byte(a, 1'b0), ack);
    check(ack, "R10 dummy write device ack", ack, 1);
    send_byte(a[7:0], ack);
    check(ack, "R10 word address ack", ack, 1);
    bus_start();
    send_byte(dev_byte(a, 1'b1), ack);
    check(ack, "R10 read device ack", ack, 1);
    mptr = a;
    rd_seq(n, req);
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    bus_start();
    send_byte(dev_byte(9'd0, 1'b1), ack);
    check(ack, "R9 current read device ack", ack, 1);
    rd_seq(n, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ack, all_high;
    int polls, n, op;
    logic [8:0] a;
    logic [7:0] b;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R13 reset releases data line", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: device byte without a start
    send_byte(dev_byte(9'd0, 1'b0), ack);
    check(!ack, "R1 no ack without start", ack, 0);
    bus_stop();

    // R2: wrong fixed nibble
    bus_start();
    send_byte(8'hB0, ack);
    check(!ack, "R2 wrong nibble not acked", ack, 0);
    send_byte(8'hA0, ack);
    check(!ack, "R2 bus ignored after mismatch", ack, 0);
    bus_stop();

    // R3: forbidden page-select bit
    bus_start();
    send_byte(8'b1010_1000, ack);
    check(!ack, "R3 bit3 set not acked", ack, 0);
    bus_stop();

    // R4 / R7 / R3 / R10: byte write in upper half
    wbuf[0] = 8'h5A;
    do_write(9'h123, 1);
    poll_once(ack);
    check(!ack, "R7 first poll during write cycle", ack, 0);
    wait_ready(polls);
    check(polls >= 1, "R7 write cycle ends", polls, 1);
    rand_read(9'h123, 1, "R10 random read of written byte");
    rand_read(9'h023, 1, "R3 lower half untouched");

    // R6: partial page write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(9'h045, 3);
    wait_ready(polls);
    rand_read(9'h040, 16, "R6 partial page");

    // R5: page wrap with 18 bytes
    for (int j = 0; j < 18; j++) wbuf[j] = 8'(8'h80 + j);
    do_write(9'h08E, 18);
    wait_ready(polls);
    check(mptr == 9'h080, "R5 counter wrapped in page", mptr, 9'h080);
    cur_read(1, "R9 current read after page write");
    rand_read(9'h080, 17, "R5 page wrap and neighbour page");

    // R8: stop after word address only
    bus_start();
    send_byte(dev_byte(9'h1A7, 1'b0), ack);
    send_byte(8'hA7, ack);
    bus_stop();
    poll_once(ack);
    check(ack, "R8 no write cycle without data", ack, 1);
    mptr = 9'h1A7;
    cur_read(2, "R8 R9 counter loaded by dummy write");

    // R11: sequential read across array end
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    do_write(9'h1FE, 2);
    wait_ready(polls);
    wbuf[0] = 8'h0A; wbuf[1] = 8'h0B;
    do_write(9'h000, 2);
    wait_ready(polls);
    rand_read(9'h1FE, 4, "R11 sequential wrap to byte 0");

    // R12: host no-acknowledge ends the read
    model[9'h031] = 8'h00;
    bus_start();
    send_byte(dev_byte(9'h030, 1'b0), ack);
    send_byte(8'h30, ack);
    bus_start();
    send_byte(dev_byte(9'h030, 1'b1), ack);
    recv_byte(1'b0, b);
    all_high = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw();
      scl = 1'b1; hw();
      if (!sda_line) all_high = 1'b0;
      scl = 1'b0;
    end
    hw();
    check(all_high, "R12 line released after host nack", all_high, 1);
    bus_stop();
    mptr = 9'h031;
    cur_read(1, "R12 R9 counter after ended read");

    // random mix
    for (int t = 0; t < 22; t++) begin
      op = int'($urandom_range(0, 2));
      a = 9'($urandom_range(0, 511));
      if (op == 0) begin
        n = int'($urandom_range(1, 20));
        for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
        do_write(a, n);
        wait_ready(polls);
      end else if (op == 1) begin
        rand_read(a, int'($urandom_range(1, 6)), "R10 R11 random read");
      end else begin
        cur_read(int'($urandom_range(1, 3)), "R9 random current read");
      end
    end

    summary();
    $finish;
  end
endmodule